// File: doc/BRIEF.md
# Toggle-Handshake Stack Memory

This block is a single-port, word-addressed memory used as the stack store of a datapath run by a state machine. Instead of a level valid signal, requests follow a phase-toggle handshake. The controller owns a request phase bit. The memory owns an acknowledge phase bit. A request is pending whenever the two bits differ. The memory serves it at the next clock edge and then copies the request phase onto its acknowledge phase, which marks the request as complete.

Each served request is either a store or a load, chosen by the write select. A store writes the data input into the addressed word and leaves the read data as it was. A load places the addressed word on the read data output. When the two phase bits match, nothing changes. All state updates take effect at the rising clock edge. The controller may issue a new request by flipping its phase bit in the same cycle it sees completion, so one request can be served on every edge.

Top module: `tgl_stack_ram`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears ack_phase to 0 and rd_data to 0. It leaves the memory contents untouched: a word stored before reset reads back unchanged afterwards.
- R2: While req_phase equals ack_phase, a clock edge changes neither rd_data nor any memory word, whatever is driven on wr_sel, addr and wr_data.
- R3: When req_phase differs from ack_phase and wr_sel is 0, rd_data holds the word at addr after the next rising edge.
- R4: When req_phase differs from ack_phase and wr_sel is 1, the word at addr takes the value of wr_data at the next rising edge, and rd_data keeps its previous value.
- R5: At every rising edge where the phases differ, ack_phase takes the value of req_phase, so the phases are equal one cycle after the request.
- R6: Requests issued on consecutive cycles, with req_phase flipped every cycle, are each served on their own edge with no lost or repeated access.
- R7: A load issued on the cycle right after a store to the same address returns the newly stored word.
- R8: Address 0 and the highest address 2**ADDR_W-1 are each stored and loaded independently. The data width is 32 bits by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_phase | input | 1 | Controller phase bit; differs from ack_phase while a request is pending |
| wr_sel | input | 1 | 1 selects a store, 0 selects a load |
| addr | input | ADDR_W | Word index |
| wr_data | input | DATA_W | Word to store |
| ack_phase | output | 1 | Memory phase bit; equals req_phase when no request is pending |
| rd_data | output | DATA_W | Result of the most recent load |

## Verification
Every result of this block is due exactly one rising edge after the stimulus. The acknowledge phase, the loaded word and the stored word all appear one edge later, and an idle edge must leave everything as it was. The bench drives inputs on the falling edge. It advances a behavioural memory model at the following rising edge, and it compares ack_phase and rd_data with that model at the next falling edge. Every clock is therefore checked half a cycle after the edge that produced it. A stored word is checked by loading it back later, and that check lands on the cycle of the load.

// File: rtl/tgl_stack_ram.sv
module tgl_stack_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_phase,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ack_phase,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic pending;

  assign pending = req_phase != ack_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_phase <= 1'b0;
      rd_data   <= '0;
    end else if (pending) begin
      ack_phase <= req_phase;
      if (!wr_sel) rd_data <= mem[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && pending && wr_sel) mem[addr] <= wr_data;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (ack_phase == 1'b0 && rd_data == '0));

  // R5
  ack_follows_chk: assert property (@(posedge clk) disable iff (rst)
    pending |=> ack_phase == $past(req_phase));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pending |=> ($stable(rd_data) && $stable(ack_phase)));

  // R4
  store_keeps_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && wr_sel) |=> $stable(rd_data));

  // R5
  ack_toggles_chk: assert property (@(posedge clk) disable iff (rst)
    pending |=> $changed(ack_phase));
endmodule

// File: tb/tgl_stack_ram_test.sv
module tgl_stack_ram_test;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst, req_phase, wr_sel;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data;
  logic ack_phase;
  logic [DW-1:0] rd_data;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic ref_ack;
  logic [DW-1:0] ref_rd;

  always #10 clk = ~clk;

  tgl_stack_ram #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .req_phase(req_phase), .wr_sel(wr_sel),
    .addr(addr), .wr_data(wr_data), .ack_phase(ack_phase), .rd_data(rd_data));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic r, input logic w,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    rst = r; wr_sel = w; addr = a; wr_data = d;
    @(posedge clk);
    if (r) begin
      ref_ack = 1'b0;
      ref_rd = '0;
    end else if (req_phase != ref_ack) begin
      ref_ack = req_phase;
      if (w) ref_mem[a] = d;
      else ref_rd = ref_mem[a];
    end
    @(negedge clk);
    check({req, " ack"}, {31'b0, ack_phase}, {31'b0, ref_ack});
    check({req, " rd"}, rd_data, ref_rd);
  endtask

  task automatic request(input string req, input logic w,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_phase = ~req_phase;
    step(req, 1'b0, w, a, d);
  endtask

  task automatic idle(input string req, input logic w,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(req, 1'b0, w, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_phase = 1'b0; wr_sel = 1'b0; addr = '0; wr_data = '0;
    ref_ack = 1'b0; ref_rd = '0;
    @(negedge clk);
    step("R1", 1'b1, 1'b0, '0, '0);
    step("R1", 1'b1, 1'b0, '0, '0);

    for (int i = 0; i < DEPTH; i++) request("R4", 1'b1, AW'(i), $urandom);
    for (int i = 0; i < DEPTH; i++) request("R3", 1'b0, AW'(i), '0);

    request("R8", 1'b1, '0, 32'h0000_0001);
    request("R8", 1'b1, '1, 32'hFFFF_FFFE);
    request("R8", 1'b0, '0, '0);
    request("R8", 1'b0, '1, '0);

    for (int i = 0; i < 8; i++) idle("R2", 1'b1, AW'(i), 32'hDEAD_0000 + i);
    for (int i = 0; i < 8; i++) request("R2", 1'b0, AW'(i), '0);

    for (int i = 0; i < 20; i++) begin
      logic [AW-1:0] a = AW'($urandom);
      logic [DW-1:0] d = $urandom;
      request("R7", 1'b1, a, d);
      request("R7", 1'b0, a, '0);
    end

    request("R4", 1'b0, 6'd5, '0);
    request("R4", 1'b1, 6'd5, 32'h1234_5678);
    request("R4", 1'b0, 6'd5, '0);

    for (int i = 0; i < 300; i++) request("R6", 1'($urandom), AW'($urandom), $urandom);

    for (int i = 0; i < 300; i++) begin
      if ($urandom % 3 == 0) idle("R2", 1'($urandom), AW'($urandom), $urandom);
      else request("R5", 1'($urandom), AW'($urandom), $urandom);
    end

    request("R1", 1'b1, 6'd9, 32'hCAFE_F00D);
    req_phase = 1'b0;
    step("R1", 1'b1, 1'b0, '0, '0);
    request("R1", 1'b0, 6'd9, '0);
    check("R1 keep", rd_data, 32'hCAFE_F00D);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule